// File: doc/BRIEF.md
# Banked GPIO Interrupt Detector

This block turns sampled GPIO input words into interrupts. The inputs are grouped into banks of 32 lanes. A frame strobe marks each newly completed capture. On that strobe the block compares the new word of each bank with the word from the frame before. It sets a sticky pending bit for every lane whose trigger condition holds and whose enable bit is set. The pending bits of all banks are ORed into one interrupt output.

Each lane is configured through four per-bank registers: an enable word, a polarity word, a level/edge mode word and a both-edges word. The mode word selects edge or level detection. The polarity word selects which edge or level counts. In edge mode the both-edges word makes any change count, whatever the polarity. Pending bits are cleared by writing ones to the bank's status word. Software uses a simple word-wide register port: writes take effect at the clock edge and reads are combinational.

Top module: `bank_irq_detector`

## Requirements
- R1: While reset is asserted and right after it, every register reads zero and `irqOut` is low. With all configuration at zero, a lane is in single falling-edge mode with its interrupt disabled.
- R2: The register address is `{bank, field}`, with field in `regAddr[2:0]`. The field codes are: 0 enable, 1 polarity, 2 mode (1 = level, 0 = edge), 3 both-edges, 4 status. Enable, polarity, mode and both-edges words read back the last value written.
- R3: In edge mode with polarity 0 and both-edges 0, a lane pends when its previous bit is 1 and its new bit is 0. A rising lane or a steady lane does not pend.
- R4: In edge mode with polarity 1 and both-edges 0, a lane pends only on a 0-to-1 change.
- R5: In edge mode with both-edges 1, a lane pends on any change, whatever its polarity bit.
- R6: In level mode, a lane pends when its new bit equals its polarity bit, whatever its both-edges bit. It pends again on every frame while that holds, including the frame right after a clear.
- R7: A lane whose enable bit is 0 never sets its pending bit.
- R8: Pending bits are set only in a cycle where `frameValid` is high. Input words presented without the strobe have no effect.
- R9: Writing the status field clears each pending bit written with 1 and leaves bits written with 0 unchanged.
- R10: When a frame sets a pending bit and a status write clears that same bit in the same cycle, the bit ends up set.
- R11: `irqOut` is high exactly when at least one pending bit in any bank is set. Banks are detected and cleared independently.
- R12: Field codes 5 to 7 read zero, and writes to them change no register.
- R13: A configuration write that lands in the same cycle as a frame takes effect from the next frame. The frame in that cycle is judged with the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | One-cycle strobe: a new capture has completed |
| curWord | input | NUM_BANKS*LANES | Newly captured input bits, bank 0 in the low lanes |
| prevWord | input | NUM_BANKS*LANES | Input bits of the previous frame |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | BANK_W+3 | Register address `{bank, field}` |
| regWrData | input | LANES | Register write data |
| regRdData | output | LANES | Combinational read data for `regAddr` |
| irqOut | output | 1 | Combined interrupt, OR of all pending bits |

## Verification
Two things can fall in the same cycle: a frame that sets pending bits, and a register write to the same bank. That write may be a status clear or a configuration change. The bench provokes both on purpose. It holds a level-mode lane active while it writes ones to its status word in the frame cycle. It also mixes random configuration writes, random status clears and random frames, so that these collide often. A behavioural model applies set-after-clear and old-configuration-for-this-frame ordering and is compared with the read port and `irqOut` on every clock.

// File: rtl/bank_irq_pkg.sv
package bank_irq_pkg;

  localparam int FIELD_W = 3;

  typedef enum logic [FIELD_W-1:0] {
    FLD_ENABLE   = 3'd0,
    FLD_POLARITY = 3'd1,
    FLD_MODE     = 3'd2,
    FLD_BOTH     = 3'd3,
    FLD_STATUS   = 3'd4,
    FLD_RSV5     = 3'd5,
    FLD_RSV6     = 3'd6,
    FLD_RSV7     = 3'd7
  } field_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   cfgWr;   // write to a configuration word
    logic   stsClr;  // write-one-to-clear on the status word
    logic   sample;  // a frame completed this cycle
    logic   bankOk;  // bank index names an existing bank
    field_e field;   // addressed field
  } strobe_t;

endpackage

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import bank_irq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = BANK_W + FIELD_W
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              frameValid,
  output strobe_t           st,
  output logic [BANK_W-1:0] bankIdx
);

  logic   bankOk;
  field_e field;
  logic   isCfg;

  always_comb begin
    bankIdx = regAddr[ADDR_W-1:FIELD_W];
    field   = field_e'(regAddr[FIELD_W-1:0]);
    bankOk  = ({1'b0, bankIdx} < (BANK_W+1)'(NUM_BANKS));
    isCfg   = (field == FLD_ENABLE) || (field == FLD_POLARITY) ||
              (field == FLD_MODE)   || (field == FLD_BOTH);

    st.cfgWr  = regWrEn && bankOk && isCfg;
    st.stsClr = regWrEn && bankOk && (field == FLD_STATUS);
    st.sample = frameValid;
    st.bankOk = bankOk;
    st.field  = field;
  end

endmodule

// File: rtl/bank_irq_slice.sv
module bank_irq_slice
  import bank_irq_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic             sel,
  input  logic [LANES-1:0] wrData,
  input  logic [LANES-1:0] curBits,
  input  logic [LANES-1:0] prevBits,
  output logic [LANES-1:0] rdWord,
  output logic             pending
);

  logic [LANES-1:0] enQ, polQ, modeQ, bothQ, stsQ;
  logic [LANES-1:0] riseV, fallV, chgV, edgeHit, levelHit, hitV;
  logic [LANES-1:0] setMask, clrMask;

  // trigger evaluation on the registered configuration
  always_comb begin
    riseV    = curBits & ~prevBits;
    fallV    = ~curBits & prevBits;
    chgV     = curBits ^ prevBits;
    edgeHit  = (bothQ & chgV) |
               (~bothQ & polQ & riseV) |
               (~bothQ & ~polQ & fallV);
    levelHit = (polQ & curBits) | (~polQ & ~curBits);
    hitV     = (modeQ & levelHit) | (~modeQ & edgeHit);
    setMask  = st.sample ? (enQ & hitV) : '0;
    clrMask  = (st.stsClr && sel) ? wrData : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      polQ  <= '0;
      modeQ <= '0;
      bothQ <= '0;
      stsQ  <= '0;
    end else begin
      if (st.cfgWr && sel) begin
        case (st.field)
          FLD_ENABLE:   enQ   <= wrData;
          FLD_POLARITY: polQ  <= wrData;
          FLD_MODE:     modeQ <= wrData;
          FLD_BOTH:     bothQ <= wrData;
          default:      ;
        endcase
      end
      // clear first, then set: a set in the same cycle survives
      stsQ <= (stsQ & ~clrMask) | setMask;
    end
  end

  always_comb begin
    case (st.field)
      FLD_ENABLE:   rdWord = enQ;
      FLD_POLARITY: rdWord = polQ;
      FLD_MODE:     rdWord = modeQ;
      FLD_BOTH:     rdWord = bothQ;
      FLD_STATUS:   rdWord = stsQ;
      default:      rdWord = '0;
    endcase
  end

  assign pending = |stsQ;

endmodule

// File: rtl/bank_irq_datapath.sv
module bank_irq_datapath
  import bank_irq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int LANES     = 32,
  parameter int BANK_W    = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    st,
  input  logic [BANK_W-1:0]          bankIdx,
  input  logic [LANES-1:0]           wrData,
  input  logic [NUM_BANKS*LANES-1:0] curWord,
  input  logic [NUM_BANKS*LANES-1:0] prevWord,
  output logic [LANES-1:0]           rdData,
  output logic                       irqOut
);

  logic [LANES-1:0] rdWords [NUM_BANKS];
  logic [NUM_BANKS-1:0] pendV;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bankIdx == BANK_W'(b));

    bank_irq_slice #(.LANES(LANES)) uSlice (
      .clk      (clk),
      .rstN     (rstN),
      .st       (st),
      .sel      (sel),
      .wrData   (wrData),
      .curBits  (curWord[b*LANES +: LANES]),
      .prevBits (prevWord[b*LANES +: LANES]),
      .rdWord   (rdWords[b]),
      .pending  (pendV[b])
    );
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (st.bankOk && (bankIdx == BANK_W'(b))) rdData = rdWords[b];
    end
  end

  assign irqOut = |pendV;

endmodule

// File: rtl/bank_irq_detector.sv
module bank_irq_detector
  import bank_irq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int LANES     = 32,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = BANK_W + FIELD_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameValid,
  input  logic [NUM_BANKS*LANES-1:0] curWord,
  input  logic [NUM_BANKS*LANES-1:0] prevWord,
  input  logic                       regWrEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [LANES-1:0]           regWrData,
  output logic [LANES-1:0]           regRdData,
  output logic                       irqOut
);

  strobe_t           st;
  logic [BANK_W-1:0] bankIdx;

  bank_irq_ctrl #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
  ) uCtrl (
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .frameValid (frameValid),
    .st         (st),
    .bankIdx    (bankIdx)
  );

  bank_irq_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .LANES     (LANES),
    .BANK_W    (BANK_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .bankIdx  (bankIdx),
    .wrData   (regWrData),
    .curWord  (curWord),
    .prevWord (prevWord),
    .rdData   (regRdData),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/bank_irq_detector_chk.sv
module bank_irq_detector_chk #(
  parameter int NUM_BANKS = 4,
  parameter int LANES     = 32,
  parameter int ADDR_W    = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameValid,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [LANES-1:0]  regWrData,
  input logic [LANES-1:0]  regRdData,
  input logic              irqOut
);

  logic bankOk;
  assign bankOk = (int'(regAddr[ADDR_W-1:3]) < NUM_BANKS);

  // R1: quiet while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!irqOut && (regRdData == '0));
    end
  end

  // R2: a configuration word reads back what was written
  p_cfg_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && bankOk && (regAddr[2:0] < 3'd4)) |=>
      ($stable(regAddr) |-> (regRdData == $past(regWrData))));

  // R8: the interrupt can only rise after a frame strobe
  p_rise_needs_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(frameValid));

  // R9: the interrupt can only fall after a status write
  p_fall_needs_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(regWrEn && (regAddr[2:0] == 3'd4)));

  // R11: no pending status visible while the interrupt is low
  p_status_vs_irq_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && (regAddr[2:0] == 3'd4)) |-> (regRdData == '0));

  // R12: unused field codes read zero
  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[2:0] > 3'd4) |-> (regRdData == '0));

endmodule

bind bank_irq_detector bank_irq_detector_chk #(
  .NUM_BANKS (NUM_BANKS),
  .LANES     (LANES),
  .ADDR_W    (ADDR_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .frameValid (frameValid),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .irqOut     (irqOut)
);

// File: tb/bank_irq_detector_test.sv
`timescale 1ns/1ps
module bank_irq_detector_test;

  localparam int NB = 4;
  localparam int LN = 32;
  localparam int AW = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            frameValid = 1'b0;
  logic [NB*LN-1:0] curWord = '0;
  logic [NB*LN-1:0] prevWord = '0;
  logic            regWrEn = 1'b0;
  logic [AW-1:0]   regAddr = '0;
  logic [LN-1:0]   regWrData = '0;
  logic [LN-1:0]   regRdData;
  logic            irqOut;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural model state
  bit [LN-1:0] mEn [NB];
  bit [LN-1:0] mPol [NB];
  bit [LN-1:0] mMode [NB];
  bit [LN-1:0] mBoth [NB];
  bit [LN-1:0] mSts [NB];

  always #2.5 clk = ~clk;

  bank_irq_detector #(.NUM_BANKS(NB), .LANES(LN)) uut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid),
    .curWord(curWord), .prevWord(prevWord),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic bit trig(bit lvl, bit pol, bit both, bit c, bit p);
    if (lvl) return pol ? c : !c;
    if (both) return c != p;
    if (pol) return c && !p;
    return p && !c;
  endfunction

  function automatic bit [LN-1:0] modelRead(bit [AW-1:0] a);
    int b = int'(a) / 8;
    int f = int'(a) % 8;
    if (b >= NB) return '0;
    case (f)
      0: return mEn[b];
      1: return mPol[b];
      2: return mMode[b];
      3: return mBoth[b];
      4: return mSts[b];
      default: return '0;
    endcase
  endfunction

  // one clock: model follows the inputs held across the edge, compare at negedge
  task automatic cycle();
    bit [LN-1:0] nxt [NB];
    int wb, wf;
    @(posedge clk);
    for (int b = 0; b < NB; b++) begin
      nxt[b] = mSts[b];
      if (!rstN) begin
        mEn[b] = '0; mPol[b] = '0; mMode[b] = '0; mBoth[b] = '0; nxt[b] = '0;
        continue;
      end
      if (regWrEn && (int'(regAddr) / 8 == b) && (int'(regAddr) % 8 == 4))
        nxt[b] = nxt[b] & ~regWrData;
      if (frameValid) begin
        for (int i = 0; i < LN; i++) begin
          if (mEn[b][i] && trig(mMode[b][i], mPol[b][i], mBoth[b][i],
                                curWord[b*LN+i], prevWord[b*LN+i]))
            nxt[b][i] = 1'b1;
        end
      end
    end
    if (rstN && regWrEn) begin
      wb = int'(regAddr) / 8;
      wf = int'(regAddr) % 8;
      if (wb < NB) begin
        if (wf == 0) mEn[wb] = regWrData;
        if (wf == 1) mPol[wb] = regWrData;
        if (wf == 2) mMode[wb] = regWrData;
        if (wf == 3) mBoth[wb] = regWrData;
      end
    end
    for (int b = 0; b < NB; b++) mSts[b] = nxt[b];
    @(negedge clk);
    begin
      bit expIrq = 1'b0;
      bit [LN-1:0] expRd = modelRead(regAddr);
      for (int b = 0; b < NB; b++) if (mSts[b] != '0) expIrq = 1'b1;
      checks++;
      if (irqOut !== expIrq) begin
        errors++;
        $display("FAIL %s irqOut actual=%0b expected=%0b", tag, irqOut, expIrq);
      end
      checks++;
      if (regRdData !== expRd) begin
        errors++;
        $display("FAIL %s regRdData[addr=%0d] actual=%h expected=%h",
                 tag, regAddr, regRdData, expRd);
      end
    end
  endtask

  task automatic wr(input int b, input int f, input logic [LN-1:0] d);
    regWrEn = 1'b1; regAddr = AW'(b*8 + f); regWrData = d;
    cycle();
    regWrEn = 1'b0;
  endtask

  task automatic look(input int b, input int f);
    regAddr = AW'(b*8 + f);
    cycle();
  endtask

  task automatic frm(input logic [NB*LN-1:0] c, input logic [NB*LN-1:0] p);
    curWord = c; prevWord = p; frameValid = 1'b1;
    cycle();
    frameValid = 1'b0;
  endtask

  function automatic logic [NB*LN-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic clearAll();
    for (int b = 0; b < NB; b++) wr(b, 4, '1);
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) cycle();
    rstN = 1'b1;
    for (int a = 0; a < 32; a++) begin regAddr = AW'(a); cycle(); end

    // R2: configuration read back, distinct per bank and field
    tag = "R2";
    for (int b = 0; b < NB; b++)
      for (int f = 0; f < 4; f++) begin
        wr(b, f, 32'hA5C3_0000 ^ LN'(b << 8) ^ LN'(f));
        look(b, f);
      end
    for (int b = 0; b < NB; b++) for (int f = 0; f < 4; f++) wr(b, f, '0);

    // R3: default falling edge
    tag = "R3";
    wr(0, 0, '1);
    look(0, 4);
    frm(128'h0000_0031, 128'h0000_00F0);
    look(0, 4);
    clearAll();

    // R4: rising edge
    tag = "R4";
    wr(1, 1, 32'h0000_FFFF); wr(1, 0, '1);
    look(1, 4);
    frm({64'h0, 32'h0F0F_0F0F, 32'h0}, {64'h0, 32'h00FF_00F0, 32'h0});
    look(1, 4);
    clearAll();

    // R5: both edges ignore polarity
    tag = "R5";
    wr(2, 3, '1); wr(2, 1, 32'h0000_FFFF); wr(2, 0, '1);
    look(2, 4);
    frm({32'h0, 32'h1234_5678, 64'h0}, {32'h0, 32'h8765_4321, 64'h0});
    clearAll();

    // R6: level mode, re-arms after a clear while held
    tag = "R6";
    wr(3, 2, '1); wr(3, 1, 32'hFFFF_0000); wr(3, 3, 32'h0F0F_0F0F); wr(3, 0, '1);
    look(3, 4);
    frm({32'hF0F0_0F0F, 96'h0}, {32'hF0F0_0F0F, 96'h0});
    wr(3, 4, '1);
    look(3, 4);
    frm({32'hF0F0_0F0F, 96'h0}, {32'h0, 96'h0});
    look(3, 4);

    // R10: set and clear on the same bit in the same cycle
    tag = "R10";
    curWord = {32'hF0F0_0F0F, 96'h0}; prevWord = curWord;
    frameValid = 1'b1;
    wr(3, 4, '1);
    frameValid = 1'b0;
    look(3, 4);
    for (int f = 0; f < 4; f++) wr(3, f, '0);
    clearAll();

    // R7: disabled lanes never pend
    tag = "R7";
    wr(0, 0, 32'h0000_FFFF); wr(0, 3, '1);
    look(0, 4);
    for (int k = 0; k < 6; k++) frm(rnd(), rnd());

    // R9: writing zeros keeps status, partial mask clears only those bits
    tag = "R9";
    wr(0, 4, '0);
    look(0, 4);
    wr(0, 4, 32'h0000_00FF);
    look(0, 4);
    clearAll();

    // R8: edges without the strobe are ignored
    tag = "R8";
    look(0, 4);
    curWord = '0; prevWord = '1;
    repeat (4) cycle();
    curWord = '0; prevWord = '0;

    // R12: unused field codes
    tag = "R12";
    wr(0, 5, 32'hDEAD_BEEF); wr(1, 6, '1); wr(2, 7, '1);
    for (int f = 5; f < 8; f++) look(0, f);
    look(0, 0); look(1, 0); look(2, 0);

    // R13: config write colliding with a frame uses the old config
    tag = "R13";
    for (int b = 0; b < NB; b++) for (int f = 0; f < 4; f++) wr(b, f, '0);
    wr(1, 0, '1);
    curWord = '0; prevWord = {64'h0, 32'hFFFF_FFFF, 32'h0};
    frameValid = 1'b1;
    wr(1, 1, '1);
    frameValid = 1'b0;
    look(1, 4);
    clearAll();

    // R11: random mix across banks
    tag = "R11";
    for (int k = 0; k < 400; k++) begin
      frameValid = ($urandom % 3) == 0;
      curWord = rnd(); prevWord = rnd();
      regWrEn = ($urandom % 2) == 0;
      regAddr = AW'($urandom);
      regWrData = $urandom;
      if (($urandom % 4) == 0) regWrData = '1;
      cycle();
    end
    regWrEn = 1'b0; frameValid = 1'b0;
    clearAll();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule